// File: doc/BRIEF.md
# Serial Switch-Select Controller

This block receives an 8-bit command over a three-wire serial link (an active-low frame strobe, a serial clock and a data line) and turns it into one-hot enable lines for an array of analog switches. All three serial inputs are brought into a faster system clock through synchronizer flops. Edges are detected in that clock domain. The serial clock must therefore run at no more than a quarter of the system clock rate.

A falling edge on the frame strobe opens a frame. Bits are taken on falling serial-clock edges, most significant bit first. On the eighth edge the command is applied on its own, whatever the frame strobe does afterwards. A build-time parameter picks one of two layouts. The single layout has one bank of 32 channels. The dual layout has two banks of 16 channels, and each bank has its own select bit. When a bank moves from one channel to a different one, all of its enables go off for one system clock first, so the switching is break-before-make.

Top module: `serial_mux_ctl`

## Requirements
- R1: After reset every enable output is 0, and it stays 0 until a complete 8-bit command has been applied.
- R2: Only a high-to-low transition of `frameN` opens a frame. Bits are captured on falling `sclk` edges while `frameN` is low, and the first bit received becomes bit 7 of the command. Edges seen while `frameN` is high change nothing.
- R3: On the eighth captured edge the command is applied even if `frameN` is still low. Further `sclk` edges in the same frame are ignored.
- R4: Single layout (DUAL_MODE=0): bit 7 is the enable-off flag, bit 6 is an active-low select, bit 5 is unused, and bits 4..0 hold the address n. A command with bit 6 = 0 and bit 7 = 0 drives exactly `swEn[n]` high (channel n+1).
- R5: Dual layout (DUAL_MODE=1): bit 7 is the enable-off flag, bit 6 is the active-low select of bank A, bit 5 is the active-low select of bank B, bit 4 is unused, and bits 3..0 hold the address n. With bit 7 = 0, each selected bank enables only channel n: bank A drives `swEn[n]` and bank B drives `swEn[16+n]`. An unselected bank keeps its previous enables.
- R6: A command whose select bits are all 1 leaves every enable unchanged, whatever the value of bit 7.
- R7: A command with at least one select bit at 0 and bit 7 = 1 turns off every enable in every bank.
- R8: If `frameN` rises before eight bits have arrived, the partial command is discarded and the bit count starts over at the next frame.
- R9: A bank never goes straight from one enabled channel to a different one. At least one system-clock cycle with the whole bank off comes in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Active-low frame strobe, asynchronous to `clk` |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdata | input | 1 | Serial data, most significant bit first |
| swEn | output | 32 | Switch enables; in the dual layout, bits 15..0 belong to bank A and bits 31..16 to bank B |

## Verification
The assertions rely on two assumptions about the inputs. Each `sclk` level is held for at least two system clocks, so one serial edge can never yield two captures. Commands are spaced far enough apart that a delayed second step of a break-before-make change finishes before the next command is applied. The stimulus holds each `sclk` level for four system clocks. It changes `sdata` only while `sclk` is high, and it keeps `frameN` steady for several system clocks around each transition, so every command arrives many cycles after the one before.

// File: rtl/serial_mux_pkg.sv
package serial_mux_pkg;
  localparam int SMUX_WORD_BITS = 8;
  localparam int SMUX_CHANNELS  = 32;

  typedef struct packed {
    logic shift;   // take one serial bit into the command register
    logic commit;  // a full command is waiting to be applied
  } smuxStrobe_t;
endpackage

// File: rtl/smux_sync.sv
module smux_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/smux_ctrl.sv
module smux_ctrl
  import serial_mux_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_BITS   = SMUX_WORD_BITS
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        sclk,
  input  logic        sdata,
  output smuxStrobe_t strb,
  output logic        bitOut
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);

  logic frameSync, clkSync, dataSync;
  logic framePrev, clkPrev;
  logic active, commitQ;
  logic [CNT_W-1:0] bitCnt;
  logic frameStart, clkFall, takeBit;

  smux_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_syncFrame (
    .clk(clk), .rstN(rstN), .din(frameN), .dout(frameSync));
  smux_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_syncClk (
    .clk(clk), .rstN(rstN), .din(sclk), .dout(clkSync));
  smux_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncData (
    .clk(clk), .rstN(rstN), .din(sdata), .dout(dataSync));

  assign frameStart = framePrev & ~frameSync;
  assign clkFall    = clkPrev & ~clkSync;
  assign takeBit    = active & ~frameSync & clkFall & ~frameStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      framePrev <= 1'b1;
      clkPrev   <= 1'b1;
      active    <= 1'b0;
      bitCnt    <= '0;
      commitQ   <= 1'b0;
    end else begin
      framePrev <= frameSync;
      clkPrev   <= clkSync;
      commitQ   <= 1'b0;
      if (frameStart) begin
        active <= 1'b1;
        bitCnt <= '0;
      end else if (active && frameSync) begin
        active <= 1'b0;           // frame closed early: drop it
        bitCnt <= '0;
      end else if (takeBit) begin
        if (bitCnt == LAST_IDX) begin
          active  <= 1'b0;        // stop taking bits until a new frame
          bitCnt  <= '0;
          commitQ <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  assign strb.shift  = takeBit;
  assign strb.commit = commitQ;
  assign bitOut      = dataSync;
endmodule

// File: rtl/smux_datapath.sv
module smux_datapath
  import serial_mux_pkg::*;
#(
  parameter bit DUAL_MODE = 1'b0,
  parameter int WORD_BITS = SMUX_WORD_BITS,
  parameter int CHANNELS  = SMUX_CHANNELS
) (
  input  logic                clk,
  input  logic                rstN,
  input  smuxStrobe_t         strb,
  input  logic                bitIn,
  output logic [CHANNELS-1:0] swEn
);
  localparam int NUM_BANKS = DUAL_MODE ? 2 : 1;
  localparam int BANK_CH   = CHANNELS / NUM_BANKS;
  localparam int ADDR_W    = $clog2(BANK_CH);

  logic [WORD_BITS-1:0] cmdReg;
  logic [NUM_BANKS-1:0] selN;
  logic                 offFlag, anySel;
  logic [ADDR_W-1:0]    addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cmdReg <= '0;
    else if (strb.shift) cmdReg <= {cmdReg[WORD_BITS-2:0], bitIn};
  end

  assign offFlag = cmdReg[WORD_BITS-1];
  assign addr    = cmdReg[ADDR_W-1:0];
  assign anySel  = ~&selN;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_CH-1:0] bankQ, pendQ, target;
    logic               pendV;

    assign selN[b] = cmdReg[WORD_BITS-2-b];
    assign target  = BANK_CH'(1) << addr;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankQ <= '0;
        pendQ <= '0;
        pendV <= 1'b0;
      end else if (strb.commit && anySel) begin
        if (offFlag) begin
          bankQ <= '0;
          pendV <= 1'b0;
        end else if (!selN[b]) begin
          if (bankQ == '0 || bankQ == target) begin
            bankQ <= target;
            pendV <= 1'b0;
          end else begin
            bankQ <= '0;        // open the old channel first
            pendQ <= target;
            pendV <= 1'b1;
          end
        end
      end else if (pendV) begin
        bankQ <= pendQ;
        pendV <= 1'b0;
      end
    end

    assign swEn[b*BANK_CH +: BANK_CH] = bankQ;
  end
endmodule

// File: rtl/serial_mux_ctl.sv
module serial_mux_ctl
  import serial_mux_pkg::*;
#(
  parameter bit DUAL_MODE   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameN,
  input  logic                     sclk,
  input  logic                     sdata,
  output logic [SMUX_CHANNELS-1:0] swEn
);
  smuxStrobe_t strb;
  logic        serialBit;

  smux_ctrl #(.SYNC_STAGES(SYNC_STAGES), .WORD_BITS(SMUX_WORD_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .sclk(sclk), .sdata(sdata),
    .strb(strb), .bitOut(serialBit));

  smux_datapath #(.DUAL_MODE(DUAL_MODE), .WORD_BITS(SMUX_WORD_BITS),
                  .CHANNELS(SMUX_CHANNELS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIn(serialBit), .swEn(swEn));
endmodule

// File: rtl/serial_mux_ctl_chk.sv
module serial_mux_ctl_chk
  import serial_mux_pkg::*;
#(
  parameter bit DUAL_MODE = 1'b0
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [SMUX_CHANNELS-1:0] swEn,
  input smuxStrobe_t              strb
);
  localparam int HALF = SMUX_CHANNELS / 2;

  // R1: enables stay off in the cycle after reset
  p_reset_off_r1: assert property (@(posedge clk) !rstN |=> swEn == '0);

  // R6: enables move only right after a command has been applied
  p_change_needs_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(swEn) |-> ($past(strb.commit) || $past(strb.commit, 2)));

  // R3: a capture never coincides with a pending apply
  p_no_shift_on_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !strb.shift);

  if (DUAL_MODE) begin : g_dual
    // R5: at most one channel per bank
    p_onehot_bank_r5: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(swEn[HALF-1:0]) && $onehot0(swEn[SMUX_CHANNELS-1:HALF]));
    // R9: break-before-make in each bank
    p_bbm_lo_r9: assert property (@(posedge clk) disable iff (!rstN)
      (swEn[HALF-1:0] != '0 && $past(swEn[HALF-1:0]) != '0)
        |-> swEn[HALF-1:0] == $past(swEn[HALF-1:0]));
    p_bbm_hi_r9: assert property (@(posedge clk) disable iff (!rstN)
      (swEn[SMUX_CHANNELS-1:HALF] != '0 && $past(swEn[SMUX_CHANNELS-1:HALF]) != '0)
        |-> swEn[SMUX_CHANNELS-1:HALF] == $past(swEn[SMUX_CHANNELS-1:HALF]));
  end else begin : g_single
    // R4: at most one channel overall
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(swEn));
    // R9: break-before-make
    p_bbm_r9: assert property (@(posedge clk) disable iff (!rstN)
      (swEn != '0 && $past(swEn) != '0) |-> swEn == $past(swEn));
  end
endmodule

bind serial_mux_ctl serial_mux_ctl_chk #(.DUAL_MODE(DUAL_MODE)) u_chk (
  .clk(clk), .rstN(rstN), .swEn(swEn), .strb(strb));

// File: tb/serial_mux_ctl_bench.sv
module serial_mux_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1;
  logic sclk = 1'b1;
  logic sdata = 1'b0;
  logic [31:0] enSingle, enDual;
  logic [31:0] expSingle = '0, expDual = '0;
  int checks = 0, fails = 0;
  int bbmViol = 0;
  bit sawGap = 0;
  logic [31:0] prevSingle = '0, prevDual = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_mux_ctl #(.DUAL_MODE(1'b0)) u_serial_mux_ctl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .sclk(sclk), .sdata(sdata),
    .swEn(enSingle));
  serial_mux_ctl #(.DUAL_MODE(1'b1)) u_serial_mux_ctl_dual (
    .clk(clk), .rstN(rstN), .frameN(frameN), .sclk(sclk), .sdata(sdata),
    .swEn(enDual));

  // R9 monitor: no direct hop between two different channels in a bank
  always @(negedge clk) begin
    if (rstN) begin
      if (prevSingle != 0 && enSingle != 0 && prevSingle != enSingle) bbmViol++;
      if (prevDual[15:0] != 0 && enDual[15:0] != 0 && prevDual[15:0] != enDual[15:0]) bbmViol++;
      if (prevDual[31:16] != 0 && enDual[31:16] != 0 && prevDual[31:16] != enDual[31:16]) bbmViol++;
      if (prevSingle != 0 && enSingle == 0) sawGap = 1;
    end
    prevSingle = enSingle;
    prevDual   = enDual;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sdata = b;
    waitClk(HALF_SCLK);
    sclk = 1'b0;
    waitClk(HALF_SCLK);
    sclk = 1'b1;
  endtask

  // shift n bits of w, MSB first; optionally close the frame afterwards
  task automatic sendBits(input logic [7:0] w, input int n, input bit closeFrame);
    frameN = 1'b0;
    waitClk(HALF_SCLK);
    for (int i = 0; i < n; i++) sendBit(w[7-i]);
    waitClk(HALF_SCLK);
    if (closeFrame) begin
      frameN = 1'b1;
      waitClk(12);
    end else begin
      waitClk(8);
    end
  endtask

  function automatic logic [31:0] modelSingle(input logic [31:0] cur, input logic [7:0] w);
    if (w[6]) return cur;
    if (w[7]) return '0;
    return 32'd1 << w[4:0];
  endfunction

  function automatic logic [31:0] modelDual(input logic [31:0] cur, input logic [7:0] w);
    logic [31:0] r = cur;
    if (w[6] && w[5]) return cur;
    if (w[7]) return '0;
    if (!w[6]) r[15:0]  = 16'd1 << w[3:0];
    if (!w[5]) r[31:16] = 16'd1 << w[3:0];
    return r;
  endfunction

  task automatic applyModel(input logic [7:0] w);
    expSingle = modelSingle(expSingle, w);
    expDual   = modelDual(expDual, w);
  endtask

  initial begin
    waitClk(3);
    check("R1 single reset", enSingle, 32'h0);
    check("R1 dual reset", enDual, 32'h0);
    rstN = 1'b1;
    waitClk(4);
    check("R1 single idle", enSingle, 32'h0);

    // R2: clock edges with frame high do nothing
    for (int i = 0; i < 8; i++) sendBit(1'b0);
    waitClk(10);
    check("R2 no frame single", enSingle, 32'h0);
    check("R2 no frame dual", enDual, 32'h0);

    // exhaustive sweep of all commands in both layouts
    for (int w = 0; w < 256; w++) begin
      logic [7:0] cw = 8'(w);
      string tagS, tagD;
      sendBits(cw, 8, 1'b1);
      applyModel(cw);
      tagS = cw[6] ? "R6 single keep" : (cw[7] ? "R7 single off" : "R4 R2 single select");
      tagD = (cw[6] && cw[5]) ? "R6 dual keep" : (cw[7] ? "R7 dual off" : "R5 R2 dual select");
      check($sformatf("%s word %h", tagS, cw), enSingle, expSingle);
      check($sformatf("%s word %h", tagD, cw), enDual, expDual);
    end

    // R3: applied while frame still low, extra bits ignored
    sendBits(8'h05, 8, 1'b0);
    applyModel(8'h05);
    check("R3 applied with frame low single", enSingle, expSingle);
    check("R3 applied with frame low dual", enDual, expDual);
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    waitClk(12);
    check("R3 extra bits ignored single", enSingle, expSingle);
    check("R3 extra bits ignored dual", enDual, expDual);
    frameN = 1'b1;
    waitClk(12);

    // R8: partial frame dropped, next full frame counted from zero
    sendBits(8'h0A, 5, 1'b1);
    check("R8 partial dropped single", enSingle, expSingle);
    check("R8 partial dropped dual", enDual, expDual);
    sendBits(8'h0B, 8, 1'b1);
    applyModel(8'h0B);
    check("R8 next frame single", enSingle, expSingle);
    check("R8 next frame dual", enDual, expDual);

    // R9: channel change passes through an all-off cycle
    sendBits(8'h03, 8, 1'b1);
    applyModel(8'h03);
    sawGap = 0;
    sendBits(8'h07, 8, 1'b1);
    applyModel(8'h07);
    check("R9 gap seen", 32'(sawGap), 32'd1);
    check("R9 new channel single", enSingle, expSingle);
    check("R9 no direct hop", 32'(bbmViol), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule